// File: doc/BRIEF.md
# Code Clock Pulse Insert/Swallow Controller

This block steers the code phase of a locally generated spreading code. It does this by editing the enable stream that clocks the code generator, so the generator never has to be reloaded. A reference chip-rate enable arrives on `chip_tick_i`. In normal running, each reference tick passes through, one cycle later, as a code enable on `code_en_o`.

A request to advance adds one extra code enable inside one sequence period, which moves the replica one chip ahead. A request to retard removes one enable, which moves the replica one chip behind. Only one adjustment is made per sequence period. A divide-by-`SEQ_LEN` counter runs on the edited enables, so the sequence strobe stays aligned with the replica code. That strobe, `seq_strobe_o`, also times the correlator dump or sample-and-hold.

All pins are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure. Requests are single-cycle pulses that the block either accepts or drops. Every output is registered and lags the input that caused it by one system clock.

Top module: `code_clk_editor`

## Requirements
- R1: `chip_tick_i` is never high in two consecutive system cycles, which means the system clock runs at least twice the chip rate.
- R2: When no adjustment is in progress, `code_en_o` equals `chip_tick_i` delayed by exactly one cycle.
- R3: `seq_strobe_o` is high together with every `SEQ_LEN`-th pulse of `code_en_o`, counting edited enables. After reset, the first strobe comes with the `SEQ_LEN`-th enable, and `seq_strobe_o` is never high without `code_en_o`.
- R4: An accepted advance request is taken up at the next strobe. At the first reference tick after that strobe, the tick's enable passes, and one extra enable follows in the next cycle. The strobe-to-strobe interval then shrinks by one chip period.
- R5: An accepted retard request is taken up at the next strobe. The enable of the first reference tick after that strobe is suppressed, and the strobe interval grows by one chip period.
- R6: `adj_done_o` pulses for one cycle in the cycle the inserted enable appears, or in the cycle the suppressed enable would have appeared. It pulses exactly once per adjustment.
- R7: An advance request and a retard request that arrive in the same cycle are both dropped, so no adjustment results.
- R8: A request that arrives while another request is still waiting is dropped. At most one adjustment occurs between two strobes.
- R9: While `rst_n` is low, and after reset until the first reference tick, all outputs are low and the chip count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_tick_i | input | 1 | Reference chip-rate enable, single-cycle pulses |
| adv_req_i | input | 1 | Request to move the replica one chip ahead |
| ret_req_i | input | 1 | Request to move the replica one chip behind |
| code_en_o | output | 1 | Edited enable for the code generator |
| seq_strobe_o | output | 1 | Once-per-sequence strobe for correlator dump |
| adj_done_o | output | 1 | Pulses when an insertion or deletion takes effect |

## Verification
A chip counter that is off by any amount moves `seq_strobe_o` away from a multiple of `SEQ_LEN` enables, and this shows as a wrong strobe interval at the very next strobe. A request register that is stuck, or that is cleared too early, changes the length of the sequence after the request by one chip in the wrong direction, or leaves that length unchanged, and this shows within two strobes. An enable editor left armed shows as an enable that no reference tick explains, or as a second `adj_done_o` pulse between two strobes. Either appears in the same cycle as the fault.

// File: rtl/cce_pkg.sv
package cce_pkg;
  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_ADV  = 2'd1,
    ADJ_RET  = 2'd2
  } adj_e;
endpackage

// File: rtl/cce_req_latch.sv
// Holds one waiting request; moves it to the armed slot at a sequence wrap.
module cce_req_latch
  import cce_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv_req_i,
  input  logic ret_req_i,
  input  logic wrap_i,
  input  logic take_i,
  output adj_e arm_o
);
  adj_e pend_q;
  adj_e arm_q;
  logic xfer;

  assign xfer = wrap_i && (arm_q == ADJ_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= ADJ_NONE;
      arm_q  <= ADJ_NONE;
    end else begin
      if (take_i)    arm_q <= ADJ_NONE;
      else if (xfer) arm_q <= pend_q;

      if (pend_q == ADJ_NONE) begin
        if (adv_req_i && !ret_req_i)      pend_q <= ADJ_ADV;
        else if (ret_req_i && !adv_req_i) pend_q <= ADJ_RET;
      end else if (xfer) begin
        pend_q <= ADJ_NONE;
      end
    end
  end

  assign arm_o = arm_q;
endmodule

// File: rtl/cce_pulse_edit.sv
// Passes, swallows or follows a reference tick with an extra enable.
module cce_pulse_edit
  import cce_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  adj_e arm_i,
  output logic en_o,
  output logic take_o,
  output logic done_o
);
  logic ins_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ins_q <= 1'b0;
    else        ins_q <= tick_i && (arm_i == ADJ_ADV);
  end

  assign take_o = tick_i && (arm_i != ADJ_NONE);
  assign en_o   = (tick_i && (arm_i != ADJ_RET)) || ins_q;
  assign done_o = (tick_i && (arm_i == ADJ_RET)) || ins_q;
endmodule

// File: rtl/cce_seq_div.sv
// Counts edited enables modulo SEQ_LEN and flags the last chip.
module cce_seq_div #(
  parameter int SEQ_LEN = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic wrap_o
);
  localparam int CW = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(SEQ_LEN - 1);

  logic [CW-1:0] cnt_q;

  assign wrap_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/code_clk_editor.sv
module code_clk_editor
  import cce_pkg::*;
#(
  parameter int SEQ_LEN = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_tick_i,
  input  logic adv_req_i,
  input  logic ret_req_i,
  output logic code_en_o,
  output logic seq_strobe_o,
  output logic adj_done_o
);
  adj_e arm;
  logic en_nxt, take, done_nxt, wrap_nxt;

  cce_req_latch req_i (
    .clk(clk), .rst_n(rst_n), .adv_req_i(adv_req_i), .ret_req_i(ret_req_i),
    .wrap_i(wrap_nxt), .take_i(take), .arm_o(arm)
  );

  cce_pulse_edit edit_i (
    .clk(clk), .rst_n(rst_n), .tick_i(chip_tick_i), .arm_i(arm),
    .en_o(en_nxt), .take_o(take), .done_o(done_nxt)
  );

  cce_seq_div #(.SEQ_LEN(SEQ_LEN)) div_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_nxt), .wrap_o(wrap_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_en_o    <= 1'b0;
      seq_strobe_o <= 1'b0;
      adj_done_o   <= 1'b0;
    end else begin
      code_en_o    <= en_nxt;
      seq_strobe_o <= wrap_nxt;
      adj_done_o   <= done_nxt;
    end
  end
endmodule

// File: rtl/cce_chk.sv
module cce_chk #(
  parameter int SEQ_LEN = 15
) (
  input logic clk,
  input logic rst_n,
  input logic chip_tick_i,
  input logic code_en_o,
  input logic seq_strobe_o,
  input logic adj_done_o
);
  localparam int CW = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1;
  logic [CW-1:0] en_cnt;
  logic          done_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_cnt    <= '0;
      done_seen <= 1'b0;
    end else begin
      if (seq_strobe_o)   en_cnt <= '0;
      else if (code_en_o) en_cnt <= en_cnt + 1'b1;
      done_seen <= seq_strobe_o ? 1'b0 : (done_seen || adj_done_o);
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    chip_tick_i |=> !chip_tick_i); // R1
  AST_EN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    code_en_o |-> ($past(chip_tick_i) || adj_done_o)); // R2
  AST_STROBE_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
    seq_strobe_o |-> code_en_o); // R3
  AST_STROBE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    seq_strobe_o |-> (en_cnt == CW'(SEQ_LEN - 1))); // R3
  AST_SWALLOW_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_done_o && !code_en_o) |-> $past(chip_tick_i)); // R5
  AST_ONE_PER_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    adj_done_o |-> !done_seen); // R8
endmodule

bind code_clk_editor cce_chk #(.SEQ_LEN(SEQ_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .chip_tick_i(chip_tick_i),
  .code_en_o(code_en_o), .seq_strobe_o(seq_strobe_o), .adj_done_o(adj_done_o)
);

// File: tb/code_clk_editor_tb_top.sv
`timescale 1ns/1ps
module code_clk_editor_tb_top;
  localparam int N = 15;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_tick = 1'b0;
  logic adv_req = 1'b0;
  logic ret_req = 1'b0;
  logic code_en, seq_strobe, adj_done;

  int total = 0;
  int bad = 0;
  bit ticks_on = 0;
  bit finished = 0;
  int exp_len[$];
  int exp_done[$];
  int carried_len = N * P;
  int carried_done = 0;

  always #10 clk = ~clk;

  code_clk_editor #(.SEQ_LEN(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .chip_tick_i(chip_tick),
    .adv_req_i(adv_req), .ret_req_i(ret_req),
    .code_en_o(code_en), .seq_strobe_o(seq_strobe), .adj_done_o(adj_done)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference tick generator (R1: one pulse every P cycles)
  int tp = 0;
  always @(negedge clk) begin
    if (ticks_on) begin
      chip_tick <= (tp == 0);
      tp = (tp == P - 1) ? 0 : tp + 1;
    end else begin
      chip_tick <= 1'b0;
    end
  end

  // monitor: pops expected intervals at each strobe
  int cyc = 0;
  int last_strobe = -1;
  int en_before_first = 0;
  int dcnt = 0;
  int r2_bad = 0;
  int r1_bad = 0;
  bit prev_en = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!adj_done && (code_en != chip_tick)) r2_bad++;
      if (prev_en && code_en && !adj_done) r1_bad++;
      prev_en = code_en;
      if (adj_done) dcnt++;
      if (last_strobe < 0 && code_en) en_before_first++;
      if (seq_strobe) begin
        if (last_strobe < 0) begin
          check("R3 first strobe enable count", en_before_first, N);
        end else if (exp_len.size() > 0) begin
          int el, ed;
          el = exp_len.pop_front();
          ed = exp_done.pop_front();
          check("R3/R4/R5/R7/R8 strobe interval", cyc - last_strobe, el);
          check("R6 done pulses per interval", dcnt, ed);
        end
        last_strobe = cyc;
        dcnt = 0;
      end
    end
  end

  task automatic wait_strobe();
    do @(negedge clk); while (!seq_strobe);
  endtask

  task automatic pulse(input bit a, input bit r);
    adv_req <= a; ret_req <= r;
    @(negedge clk);
    adv_req <= 1'b0; ret_req <= 1'b0;
  endtask

  // driver: kind 0 none, 1 adv, 2 ret, 3 both, 4 adv twice, 5 ret then adv
  task automatic drive_seq(input int kind);
    wait_strobe();
    exp_len.push_back(carried_len);
    exp_done.push_back(carried_done);
    repeat (7) @(negedge clk);
    case (kind)
      1: pulse(1, 0);
      2: pulse(0, 1);
      3: pulse(1, 1);
      4: begin pulse(1, 0); repeat (3) @(negedge clk); pulse(1, 0); end
      5: begin pulse(0, 1); repeat (3) @(negedge clk); pulse(1, 0); end
      default: ;
    endcase
    case (kind)
      1, 4: begin carried_len = (N - 1) * P; carried_done = 1; end
      2, 5: begin carried_len = (N + 1) * P; carried_done = 1; end
      default: begin carried_len = N * P; carried_done = 0; end
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 code_en in reset", int'(code_en), 0);
    check("R9 strobe in reset", int'(seq_strobe), 0);
    check("R9 done in reset", int'(adj_done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 code_en after reset", int'(code_en), 0);
    ticks_on = 1;
    drive_seq(0);
    drive_seq(1);  // R4
    drive_seq(0);
    drive_seq(2);  // R5
    drive_seq(3);  // R7
    drive_seq(4);  // R8
    drive_seq(5);  // R8
    drive_seq(1);
    drive_seq(1);
    drive_seq(2);
    drive_seq(0);
    wait_strobe();
    @(negedge clk);
    check("R2 untouched enables follow ticks", r2_bad, 0);
    check("R1 no back-to-back enables outside insertion", r1_bad, 0);
    check("R3 all expected intervals seen", exp_len.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule